// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter. It keeps one 8-bit mode register, loaded by a single-cycle write strobe, which selects the run state, where conversions are started from, the conversion length, the trigger polarity and whether the reference booster is powered. It presents a trial code to an external DAC, reads a one-bit comparator answer, and after eight bit decisions publishes the 8-bit result with a one-cycle done pulse.

A conversion is started by software, through a write that sets the run bit while software start is selected, or by a chosen edge on an external trigger pin. The pin is synchronised before edge detection. Each conversion takes a fixed clock budget picked by a 3-bit code and split evenly across the eight bit decisions. Codes with no defined budget are refused. The booster enable is driven out directly. No start is accepted until a parameterised settling interval has passed since the booster was switched on.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the mode register is 0, and result, dac_code, done, busy, boost_en, boost_ready and cfg_err are all 0.
- R2: A write with bit 7 (run) = 1 and bit 6 (source) = 0 starts a conversion at that clock edge, provided the start is permitted (R6, R9). A write that starts while a conversion is running restarts it.
- R3: Bits 5:3 select the budget. Codes 000, 001, 010, 100, 101 and 110 give 144, 120, 96, 576, 480 and 384 cycles. result and done change exactly that many cycles after the starting edge.
- R4: The conversion tests bits 7 down to 0. The trial code on dac_code has the bit under test set. cmp_in = 1 means the input is at or above the trial code, and the bit is then kept. The final result equals the highest code not above the input.
- R5: done is high for exactly one cycle per completed conversion, and result changes only in that cycle.
- R6: Codes 011 and 111 are forbidden, as are 001 and 010 when BLOCK_FAST = 1. cfg_err is high while a forbidden code is held, and no conversion starts under one.
- R7: With source = 1, bits 2:1 select the trigger edge: 00 none, 01 falling, 10 rising, 11 both. ext_trig passes through two synchroniser flops, so a start occurs at the third rising clock edge after the pin changes. With source = 1, writes do not start a conversion.
- R8: boost_en follows bit 0. boost_ready rises SETTLE_CYC cycles after the write that sets bit 0, and clears at the edge of the write that clears it.
- R9: A start requested while boost_ready is 0, or by a write that clears bit 0, is ignored.
- R10: A write with run = 0 aborts a running conversion in that cycle. No done pulse is produced, and result keeps the last completed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write value |
| ext_trig | input | 1 | External start trigger, asynchronous |
| cmp_in | input | 1 | Comparator answer: input is at or above dac_code |
| dac_code | output | 8 | Trial code driven to the DAC |
| result | output | 8 | Last completed conversion result |
| done | output | 1 | One-cycle pulse when result updates |
| busy | output | 1 | Conversion in progress |
| boost_en | output | 1 | Reference booster enable |
| boost_ready | output | 1 | Booster settling interval has elapsed |
| cfg_err | output | 1 | Held conversion-time code is forbidden |

## Verification
A step counter or length latch that is off by even one cycle moves the done pulse away from its exact budget cycle. The bench samples both sides of that cycle for every legal code, so the error shows on the first conversion that uses the code. A wrong bit index or a wrong keep decision corrupts result at the same done pulse; the input values include 00, FF and alternating patterns so that every bit position is exercised. A faulty settling counter or trigger synchroniser shows on busy within a few cycles of the checked edge.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    localparam int RES_W  = 8;
    localparam int STEP_W = 7;

    typedef struct packed {
        logic       run;
        logic       hw_src;
        logic [2:0] tcode;
        logic [1:0] edge_sel;
        logic       boost;
    } mode_t;

    // cycles per bit decision: the whole budget divided by eight
    function automatic logic [STEP_W-1:0] step_len(input logic [2:0] c);
        case (c)
            3'b000:  step_len = STEP_W'(18);
            3'b001:  step_len = STEP_W'(15);
            3'b010:  step_len = STEP_W'(12);
            3'b100:  step_len = STEP_W'(72);
            3'b101:  step_len = STEP_W'(60);
            3'b110:  step_len = STEP_W'(48);
            default: step_len = '0;
        endcase
    endfunction

    function automatic logic code_bad(input logic [2:0] c, input logic block_fast);
        code_bad = (c == 3'b011) || (c == 3'b111) ||
                   (block_fast && ((c == 3'b001) || (c == 3'b010)));
    endfunction

endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.s1 = trig_async;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise = q.s2 & ~q.s3;
    assign fall = ~q.s2 & q.s3;
endmodule

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
    parameter int SETTLE_CYC = 2800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic ready
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rdy;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (!en) begin
            d.cnt = '0;
            d.rdy = 1'b0;
        end else if (q.cnt == LIMIT) begin
            d.rdy = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ready = q.rdy;
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
    import adc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [STEP_W-1:0] step_cyc,
    input  logic              cmp_in,
    output logic [RES_W-1:0]  trial,
    output logic [RES_W-1:0]  result,
    output logic              done,
    output logic              busy
);
    typedef struct packed {
        logic              busy;
        logic [2:0]        idx;
        logic [STEP_W-1:0] cnt;
        logic [STEP_W-1:0] len;
        logic [RES_W-1:0]  code;
        logic [RES_W-1:0]  res;
        logic              done;
    } sar_t;

    sar_t q, d;
    logic [RES_W-1:0] kept;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        kept   = q.code;
        kept[q.idx] = cmp_in;
        if (abort) begin
            d.busy = 1'b0;
            d.code = '0;
        end else if (start) begin
            d.busy = 1'b1;
            d.idx  = 3'd7;
            d.cnt  = '0;
            d.len  = step_cyc;
            d.code = 8'h80;
        end else if (q.busy) begin
            if (q.cnt == q.len - 1'b1) begin
                d.cnt = '0;
                if (q.idx == 3'd0) begin
                    d.res  = kept;
                    d.done = 1'b1;
                    d.busy = 1'b0;
                    d.code = '0;
                end else begin
                    d.idx  = q.idx - 3'd1;
                    d.code = kept | (8'h01 << (q.idx - 3'd1));
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign trial  = q.code;
    assign result = q.res;
    assign done   = q.done;
    assign busy   = q.busy;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int SETTLE_CYC = 2800,
    parameter bit BLOCK_FAST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    input  logic             ext_trig,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             done,
    output logic             busy,
    output logic             boost_en,
    output logic             boost_ready,
    output logic             cfg_err
);
    mode_t mode_q, mode_d;
    logic  rise, fall, edge_hit, sw_req, hw_req, start, run_q;

    always_comb begin
        mode_d = mode_q;
        if (cfg_we) mode_d = mode_t'(cfg_wdata);
        edge_hit = (mode_d.edge_sel[0] & fall) | (mode_d.edge_sel[1] & rise);
        sw_req   = cfg_we & mode_d.run & ~mode_d.hw_src;
        hw_req   = mode_d.run & mode_d.hw_src & edge_hit;
        start    = (sw_req | hw_req) & mode_d.boost & boost_ready &
                   ~code_bad(mode_d.tcode, BLOCK_FAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    adc_trig_edge u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_async (ext_trig),
        .rise       (rise),
        .fall       (fall)
    );

    adc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mode_d.boost),
        .ready (boost_ready)
    );

    adc_sar_core u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .abort    (~mode_d.run),
        .step_cyc (step_len(mode_d.tcode)),
        .cmp_in   (cmp_in),
        .trial    (dac_code),
        .result   (result),
        .done     (done),
        .busy     (busy)
    );

    assign boost_en = mode_q.boost;
    assign cfg_err  = code_bad(mode_q.tcode, BLOCK_FAST);
    assign run_q    = mode_q.run;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic       busy,
    input logic [7:0] result,
    input logic       boost_en,
    input logic       boost_ready,
    input logic       cfg_err,
    input logic       run_q
);
    AST_DONE_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);                // R3
    AST_DONE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                // R5
    AST_RESULT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(result));     // R5
    AST_ERR_NO_START:  assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !cfg_err);      // R6
    AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) boost_ready |-> boost_en);     // R8
    AST_START_READY:   assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> boost_ready);   // R9
    AST_STOP_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) !run_q |-> !busy);              // R10
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .busy        (busy),
    .result      (result),
    .boost_en    (boost_en),
    .boost_ready (boost_ready),
    .cfg_err     (cfg_err),
    .run_q       (run_q)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
    localparam int SETTLE = 40;

    typedef struct packed {
        logic [2:0]  code;
        logic [7:0]  vin;
        logic [11:0] budget;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{3'b000, 8'hA5, 12'd144},
        '{3'b001, 8'h00, 12'd120},
        '{3'b010, 8'hFF, 12'd96},
        '{3'b100, 8'h3C, 12'd576},
        '{3'b101, 8'h81, 12'd480},
        '{3'b110, 8'h7E, 12'd384}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       ext_trig = 1'b0;
    logic [7:0] vin = '0;
    logic       cmp_in;
    logic [7:0] dac_code, result;
    logic       done, busy, boost_en, boost_ready, cfg_err;
    int checks = 0;
    int errors = 0;
    int done_cnt = 0;

    always #2.5 clk = ~clk;

    assign cmp_in = (dac_code <= vin);

    adc_seq_ctrl #(.SETTLE_CYC(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ext_trig(ext_trig), .cmp_in(cmp_in), .dac_code(dac_code),
        .result(result), .done(done), .busy(busy), .boost_en(boost_en),
        .boost_ready(boost_ready), .cfg_err(cfg_err)
    );

    always @(posedge clk) if (done) done_cnt <= done_cnt + 1;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1..: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int dc;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        chk({result, dac_code, done, busy, boost_en, boost_ready, cfg_err} == '0,
            "R1 reset outputs", {result, 3'b0, done, busy, boost_en, boost_ready, cfg_err}, 16'h0);

        // R9 start before booster settles is ignored; R8 ready timing
        vin = 8'h42;
        wr(8'h81);
        chk(busy == 1'b0, "R9 start before ready", busy, 0);
        chk(boost_en == 1'b1, "R8 boost_en follows bit0", boost_en, 1);
        wait_n(SETTLE - 1);
        chk(boost_ready == 1'b0, "R8 ready not early", boost_ready, 0);
        wait_n(1);
        chk(boost_ready == 1'b1, "R8 ready on time", boost_ready, 1);

        // R2 R3 R4 R5 table of budgets and input values
        for (int i = 0; i < 6; i++) begin
            vin = VEC[i].vin;
            dc = done_cnt;
            wr({1'b1, 1'b0, VEC[i].code, 2'b00, 1'b1});
            chk(busy == 1'b1, "R2 software start", busy, 1);
            wait_n(int'(VEC[i].budget) - 1);
            chk(done == 1'b0, "R3 done not early", done, 0);
            wait_n(1);
            chk(done == 1'b1, "R3 done at budget", done, 1);
            chk(result == VEC[i].vin, "R4 result value", result, VEC[i].vin);
            wait_n(1);
            chk(done == 1'b0 && done_cnt == dc + 1, "R5 single done pulse", 16'(done_cnt - dc), 1);
        end

        // R6 forbidden codes
        vin = 8'h11;
        wr({1'b1, 1'b0, 3'b011, 2'b00, 1'b1});
        chk(cfg_err == 1'b1 && busy == 1'b0, "R6 code 011 refused", {cfg_err, busy}, 16'h2);
        wr({1'b1, 1'b0, 3'b111, 2'b00, 1'b1});
        chk(cfg_err == 1'b1 && busy == 1'b0, "R6 code 111 refused", {cfg_err, busy}, 16'h2);
        wait_n(200);
        chk(result == 8'h7E, "R6 result untouched", result, 8'h7E);

        // R10 abort keeps last result
        vin = 8'h55;
        wr({1'b1, 1'b0, 3'b000, 2'b00, 1'b1});
        chk(cfg_err == 1'b0, "R6 legal code clears err", cfg_err, 0);
        wait_n(40);
        chk(busy == 1'b1, "R10 running before abort", busy, 1);
        dc = done_cnt;
        wr(8'h01);
        chk(busy == 1'b0, "R10 abort stops", busy, 0);
        wait_n(200);
        chk(result == 8'h7E && done_cnt == dc, "R10 result kept, no done", result, 8'h7E);

        // R2 restart by a second software write
        vin = 8'h5A;
        wr({1'b1, 1'b0, 3'b000, 2'b00, 1'b1});
        wait_n(50);
        wr({1'b1, 1'b0, 3'b000, 2'b00, 1'b1});
        wait_n(143);
        chk(done == 1'b0, "R2 restart delays done", done, 0);
        wait_n(1);
        chk(done == 1'b1 && result == 8'h5A, "R2 restart result", result, 8'h5A);

        // R7 hardware trigger, rising edge select
        vin = 8'h33;
        wr(8'hC5);
        chk(busy == 1'b0, "R7 write does not start in hw mode", busy, 0);
        @(negedge clk) ext_trig = 1'b1;
        wait_n(2);
        chk(busy == 1'b0, "R7 sync delay", busy, 0);
        wait_n(1);
        chk(busy == 1'b1, "R7 rising edge start", busy, 1);
        wait_n(150);
        chk(result == 8'h33, "R7 rising result", result, 8'h33);
        @(negedge clk) ext_trig = 1'b0;
        wait_n(6);
        chk(busy == 1'b0, "R7 falling ignored in rising mode", busy, 0);

        // falling edge select
        vin = 8'h99;
        wr(8'hC3);
        @(negedge clk) ext_trig = 1'b1;
        wait_n(6);
        chk(busy == 1'b0, "R7 rising ignored in falling mode", busy, 0);
        @(negedge clk) ext_trig = 1'b0;
        wait_n(4);
        chk(busy == 1'b1, "R7 falling edge start", busy, 1);
        wait_n(150);
        chk(result == 8'h99, "R7 falling result", result, 8'h99);

        // both edges
        vin = 8'h10;
        wr(8'hC7);
        @(negedge clk) ext_trig = 1'b1;
        wait_n(4);
        chk(busy == 1'b1, "R7 both: rising", busy, 1);
        wait_n(150);
        @(negedge clk) ext_trig = 1'b0;
        wait_n(4);
        chk(busy == 1'b1, "R7 both: falling", busy, 1);
        wait_n(150);
        chk(result == 8'h10, "R7 both result", result, 8'h10);

        // no edge
        wr(8'hC1);
        @(negedge clk) ext_trig = 1'b1;
        wait_n(6);
        @(negedge clk) ext_trig = 1'b0;
        wait_n(6);
        chk(busy == 1'b0, "R7 edge select 00 never starts", busy, 0);

        // R8 booster off clears ready at once; R9 start without booster ignored
        wr(8'h00);
        chk(boost_ready == 1'b0 && boost_en == 1'b0, "R8 disable clears ready", {boost_en, boost_ready}, 0);
        wr(8'h80);
        chk(busy == 1'b0, "R9 start with booster off", busy, 0);
        wr(8'h81);
        chk(busy == 1'b0, "R9 start in settle window", busy, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule